// File: doc/BRIEF.md
# Display scanout address generator

This block computes the memory fetch addresses that a display refresh engine needs inside a graphics aperture of up to 4 MB. Software programs start offsets for the uncompressed frame buffer, the compressed display buffer and the cursor buffer. It also programs a line pitch and a per-line size word. The refresh engine supplies start-of-frame and start-of-line strobes. The block returns, for each line, a frame-buffer base address with its byte count and a compressed-buffer base address with fetch and validity flags. It also returns a linear cursor address and a sub-16-byte pixel offset.

The frame-buffer base is double buffered. A new start offset is held in a shadow register and takes effect only at the next frame start, so panning and page flipping never tear a frame. The low four bits of the same write form a pixel offset that takes effect at once. Any nonzero frame-buffer start turns compressed fetching off. A compressed line longer than the programmed limit is flagged unusable, and the engine then falls back to uncompressed data.

Top module: `scan_addr_gen`

## Requirements
- R1: After reset every output is zero.
- R2: A register write uses selector 0 for the frame-buffer start, 1 for the compressed start, 2 for the cursor start, 3 for the line pitch and 4 for the size word. Selectors 5 to 7 change nothing. Data bits above bit 21 are dropped.
- R3: Bits [21:4] of a frame-buffer start write are held aside. They reach `fb_line_addr` (low 4 bits zero) only at the next `frame_start`. A write in the same cycle as `frame_start` waits for the following frame.
- R4: `pix_offset` equals bits [3:0] of the most recent frame-buffer start write. It changes in the cycle after the write.
- R5: On a `line_start` that is not the first line of a frame, `fb_line_addr` and `cb_line_addr` each advance by the pitch. The pitch is bits [21:4] of the pitch register, with its low 4 bits taken as zero. The sum wraps modulo 2^22.
- R6: `frame_start` loads all three pointers from their start offsets. The first `line_start` of a frame, including one in the same cycle as `frame_start`, leaves them unchanged. Before the first frame after reset, the first line also counts as first.
- R7: The compressed start offset always has its low 4 bits forced to zero.
- R8: `line_vld` pulses in the cycle after each `line_start`. `fb_line_bytes` then holds bits [8:0] of the size word as it stood at that `line_start`.
- R9: `cb_line_ok` is 1 after a `line_start` only if compression is enabled and `cmp_len` is no greater than the limit in size-word bits [15:9].
- R10: `cb_fetch_en`, latched at `line_start`, is 1 only when the programmed frame-buffer start (all 22 bits) is zero.
- R11: `curs_addr` loads the cursor start at `frame_start`. It advances by `CURS_STEP` bytes (default 16) on each later line, modulo 2^22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector |
| reg_wdata | input | 32 | Write data |
| frame_start | input | 1 | Start-of-frame strobe |
| line_start | input | 1 | Start-of-line strobe |
| cmp_len | input | 7 | Length of the coming compressed line |
| line_vld | output | 1 | Line outputs updated |
| fb_line_addr | output | 22 | Frame-buffer line base |
| fb_line_bytes | output | 9 | Frame-buffer bytes per line |
| cb_line_addr | output | 22 | Compressed line base |
| cb_fetch_en | output | 1 | Compressed fetch allowed |
| cb_line_ok | output | 1 | Compressed line usable |
| pix_offset | output | 4 | Sub-16-byte pixel offset |
| curs_addr | output | 22 | Cursor fetch address |

## Verification
A register write can fall in the same cycle as a frame or line strobe. A frame-buffer start written together with `frame_start` must not reach the line pointer until a later frame. A pitch or size write that coincides with `line_start` must leave that line using the old value. The bench forces these collisions on purpose and also lets them arise in a random phase. A behavioural model then judges every output on every cycle.

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
  parameter int AW        = 22,
  parameter int BYTEW     = 9,
  parameter int LENW      = 7,
  parameter int CURS_STEP = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_sel,
  input  logic [31:0]     reg_wdata,
  input  logic            frame_start,
  input  logic            line_start,
  input  logic [LENW-1:0] cmp_len,
  output logic            line_vld,
  output logic [AW-1:0]   fb_line_addr,
  output logic [BYTEW-1:0] fb_line_bytes,
  output logic [AW-1:0]   cb_line_addr,
  output logic            cb_fetch_en,
  output logic            cb_line_ok,
  output logic [3:0]      pix_offset,
  output logic [AW-1:0]   curs_addr
);
  localparam int SZW = BYTEW + LENW;
  localparam logic [AW-1:0] CSTEP = AW'(CURS_STEP);

  logic [AW-1:0]  fb_start_q, cb_start_q, cur_start_q, pitch_q;
  logic [SZW-1:0] size_q;
  logic [AW-1:0]  fb_ptr, cb_ptr, cur_ptr;
  logic           first_q;
  logic           cmp_on;

  assign cmp_on       = (fb_start_q == '0);
  assign pix_offset   = fb_start_q[3:0];
  assign fb_line_addr = fb_ptr;
  assign cb_line_addr = cb_ptr;
  assign curs_addr    = cur_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_start_q  <= '0;
      cb_start_q  <= '0;
      cur_start_q <= '0;
      pitch_q     <= '0;
      size_q      <= '0;
    end else if (reg_wr) begin
      case (reg_sel)
        3'd0: fb_start_q  <= reg_wdata[AW-1:0];
        3'd1: cb_start_q  <= {reg_wdata[AW-1:4], 4'b0};
        3'd2: cur_start_q <= reg_wdata[AW-1:0];
        3'd3: pitch_q     <= {reg_wdata[AW-1:4], 4'b0};
        3'd4: size_q      <= reg_wdata[SZW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_ptr  <= '0;
      cb_ptr  <= '0;
      cur_ptr <= '0;
      first_q <= 1'b1;
    end else if (frame_start) begin
      fb_ptr  <= {fb_start_q[AW-1:4], 4'b0};
      cb_ptr  <= cb_start_q;
      cur_ptr <= cur_start_q;
      first_q <= ~line_start;
    end else if (line_start) begin
      if (first_q) begin
        first_q <= 1'b0;
      end else begin
        fb_ptr  <= fb_ptr + pitch_q;
        cb_ptr  <= cb_ptr + pitch_q;
        cur_ptr <= cur_ptr + CSTEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_vld      <= 1'b0;
      fb_line_bytes <= '0;
      cb_fetch_en   <= 1'b0;
      cb_line_ok    <= 1'b0;
    end else begin
      line_vld <= line_start;
      if (line_start) begin
        fb_line_bytes <= size_q[BYTEW-1:0];
        cb_fetch_en   <= cmp_on;
        cb_line_ok    <= cmp_on && (cmp_len <= size_q[SZW-1:BYTEW]);
      end
    end
  end
endmodule

module scan_addr_gen_chk #(
  parameter int AW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_sel,
  input logic [31:0]   reg_wdata,
  input logic          frame_start,
  input logic          line_start,
  input logic          first_q,
  input logic [AW-1:0] pitch_q,
  input logic          line_vld,
  input logic [AW-1:0] fb_line_addr,
  input logic [AW-1:0] cb_line_addr,
  input logic          cb_fetch_en,
  input logic          cb_line_ok,
  input logic [3:0]    pix_offset
);
  a_r4_pix_now: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_sel == 3'd0 |=> pix_offset == $past(reg_wdata[3:0]));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start && !line_start |=> $stable(fb_line_addr) && $stable(cb_line_addr));
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && !frame_start && !first_q |=>
      fb_line_addr == AW'($past(fb_line_addr) + $past(pitch_q)));
  a_r7_align: assert property (@(posedge clk) disable iff (!rst_n)
    cb_line_addr[3:0] == 4'd0);
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> line_vld);
  a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cb_line_ok |-> cb_fetch_en);
endmodule

bind scan_addr_gen scan_addr_gen_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .frame_start(frame_start), .line_start(line_start),
  .first_q(first_q), .pitch_q(pitch_q), .line_vld(line_vld),
  .fb_line_addr(fb_line_addr), .cb_line_addr(cb_line_addr),
  .cb_fetch_en(cb_fetch_en), .cb_line_ok(cb_line_ok), .pix_offset(pix_offset)
);

// File: tb/scan_addr_gen_tb.sv
module scan_addr_gen_tb_top;
  localparam int MOD = 4194304;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [2:0] reg_sel = 0; logic [31:0] reg_wdata = 0;
  logic frame_start = 0, line_start = 0; logic [6:0] cmp_len = 0;
  logic line_vld, cb_fetch_en, cb_line_ok;
  logic [21:0] fb_line_addr, cb_line_addr, curs_addr;
  logic [8:0] fb_line_bytes; logic [3:0] pix_offset;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  scan_addr_gen dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .frame_start(frame_start), .line_start(line_start),
    .cmp_len(cmp_len), .line_vld(line_vld), .fb_line_addr(fb_line_addr),
    .fb_line_bytes(fb_line_bytes), .cb_line_addr(cb_line_addr),
    .cb_fetch_en(cb_fetch_en), .cb_line_ok(cb_line_ok), .pix_offset(pix_offset),
    .curs_addr(curs_addr));

  int m_fbs, m_cbs, m_cus, m_pitch, m_size, m_fb, m_cb, m_cu, m_first;
  int m_vld, m_bytes, m_fetch, m_ok;

  task automatic m_reset();
    m_fbs = 0; m_cbs = 0; m_cus = 0; m_pitch = 0; m_size = 0;
    m_fb = 0; m_cb = 0; m_cu = 0; m_first = 1;
    m_vld = 0; m_bytes = 0; m_fetch = 0; m_ok = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int en, lim;
      en  = (m_fbs == 0);
      lim = m_size / 512;
      m_vld = line_start;
      if (line_start) begin
        m_bytes = m_size % 512; m_fetch = en;
        m_ok = en && (int'(cmp_len) <= lim);
      end
      if (frame_start) begin
        m_fb = m_fbs - (m_fbs % 16); m_cb = m_cbs; m_cu = m_cus;
        m_first = !line_start;
      end else if (line_start) begin
        if (m_first) m_first = 0;
        else begin
          m_fb = (m_fb + m_pitch) % MOD; m_cb = (m_cb + m_pitch) % MOD;
          m_cu = (m_cu + 16) % MOD;
        end
      end
      if (reg_wr) begin
        int v; v = int'(reg_wdata % MOD);
        case (reg_sel)
          0: m_fbs = v;
          1: m_cbs = v - v % 16;
          2: m_cus = v;
          3: m_pitch = v - v % 16;
          4: m_size = int'(reg_wdata % 65536);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3/R5/R6 fb_line_addr", int'(fb_line_addr), m_fb);
      chk("R5/R7 cb_line_addr", int'(cb_line_addr), m_cb);
      chk("R11 curs_addr", int'(curs_addr), m_cu);
      chk("R4 pix_offset", int'(pix_offset), m_fbs % 16);
      chk("R8 line_vld", int'(line_vld), m_vld);
      chk("R8 fb_line_bytes", int'(fb_line_bytes), m_bytes);
      chk("R10 cb_fetch_en", int'(cb_fetch_en), m_fetch);
      chk("R9 cb_line_ok", int'(cb_line_ok), m_ok);
    end
  end

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = 3'(sel); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic pulse(input logic f, input logic l, input int len);
    @(negedge clk); frame_start = f; line_start = l; cmp_len = 7'(len);
    @(negedge clk); frame_start = 0; line_start = 0;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    total++;
    if ({line_vld, fb_line_addr, fb_line_bytes, cb_line_addr, cb_fetch_en,
         cb_line_ok, pix_offset, curs_addr} != '0) begin
      bad++; $display("FAIL R1 reset outputs actual=nonzero expected=0");
    end
    rst_n = 1;
    // R2 R7: registers, unused selectors, high bits dropped
    wr(1, 32'hFFC0_123F);
    wr(2, 32'h0000_0400);
    wr(3, 32'h0000_1409);
    wr(4, {16'h0, 7'd20, 9'd320});
    wr(5, 32'hFFFF_FFFF); wr(6, 32'h1234_5678); wr(7, 32'hFFFF_FFFF);
    // R6: frame then lines, compressed enabled
    pulse(1, 0, 0);
    pulse(0, 1, 20);  // first line, R9 equal to limit
    pulse(0, 1, 21);  // R9 over limit, R5 advance
    pulse(0, 1, 3);
    // R3 R4 R10: nonzero FB start shadowed, pix offset immediate
    wr(0, 32'h0001_2347);
    pulse(0, 1, 1);
    pulse(1, 1, 1);   // R6 collision: same-cycle frame and line
    pulse(0, 1, 1);
    // R3 collision: write in the frame_start cycle
    @(negedge clk); reg_wr = 1; reg_sel = 0; reg_wdata = 32'h0;
    frame_start = 1;
    @(negedge clk); reg_wr = 0; frame_start = 0;
    pulse(0, 1, 0);
    pulse(1, 0, 0);   // zero start now active
    // R5 wrap near top of aperture
    wr(1, 32'h003F_FFF0); wr(3, 32'h0020_0000); wr(2, 32'h003F_FFF8);
    pulse(1, 0, 0);
    repeat (4) pulse(0, 1, 5);
    // R8 size write colliding with line_start
    @(negedge clk); reg_wr = 1; reg_sel = 4; reg_wdata = 32'h0000_0055;
    line_start = 1;
    @(negedge clk); reg_wr = 0; line_start = 0;
    pulse(0, 1, 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      reg_wr = ($urandom % 5 == 0);
      reg_sel = 3'($urandom % 8);
      reg_wdata = $urandom;
      if ($urandom % 3 == 0) reg_wdata[21:0] = '0;
      frame_start = ($urandom % 40 == 0);
      line_start = ($urandom % 4 == 0);
      cmp_len = 7'($urandom);
    end
    @(negedge clk); reg_wr = 0; frame_start = 0; line_start = 0;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule